// File: doc/BRIEF.md
# Wide-Word Issue Controller

This block sits at the issue point of a statically scheduled machine that fetches one long instruction word per cycle. Each word has five fixed slots: two memory slots, two floating-point slots and one integer/branch slot. The controller latches the word and raises a start strobe for every unit whose slot holds real work. Operations in one word are never checked against each other, because the compiler has already placed them so that they do not conflict. Slot position alone selects the unit.

Every slot is guarded by one of sixteen one-bit predicates held inside the controller. A slot issues only when its predicate reads true. An equality compare placed in the integer/branch slot writes a true predicate and its complement. The integer unit supplies the compare outcome on `cmp_eq` in the cycle the compare issues. If any unit reports busy, the whole machine freezes in lock step: the latched word stays put, no strobe fires and no new word is accepted.

Top module: `wide_issue_ctrl`

## Requirements
- R1: After reset no slot is latched, no strobe is raised, `in_ready` is high, and every predicate except predicate 0 reads false.
- R2: A word offered with `in_valid` high while `in_ready` is high appears on `unit_word` in the next cycle. Slot k occupies bits [33k+32:33k]. Slot 0 and slot 1 go to the memory units, slots 2 and 3 to the FP units, and slot 4 to the integer/branch unit.
- R3: Within a slot, bit 32 is the valid bit, and 0 marks a no-op. Bits 31:28 hold the predicate index, bits 27:24 the opcode, bits 23:16 the destination field, and bits 15:8 and 7:0 the source fields. A no-op slot never raises its unit strobe.
- R4: A valid slot raises its strobe only when the predicate named by its index is true. Otherwise it is squashed, and a squashed compare writes no predicate.
- R5: Predicate 0 always reads true, and compare writes to it are dropped.
- R6: When the integer/branch slot issues opcode 4'h1 (equality compare), the predicate in destination bits 23:20 takes `cmp_eq` and the predicate in bits 19:16 takes its inverse.
- R7: Predicate writes from a compare take effect for the next word. Slots in the word that holds the compare see the old values.
- R8: When both compare destinations name the same predicate, that predicate takes the inverse of `cmp_eq`.
- R9: While any bit of `unit_busy` is high, every bit of `unit_go` is low.
- R10: While any bit of `unit_busy` is high, the latched word and its validity are held unchanged, and an offered word is not taken.
- R11: `in_ready` is high exactly when no bit of `unit_busy` is high.
- R12: Valid, true-guarded slots that name the same destination or source fields in one word all issue together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered on `in_word` |
| in_word | input | 165 | Offered word, five 33-bit slots |
| in_ready | output | 1 | The offered word is taken at this edge |
| unit_busy | input | 5 | Per-unit busy, one bit per slot position |
| cmp_eq | input | 1 | Compare outcome from the integer unit |
| unit_go | output | 5 | Per-unit start strobe |
| unit_word | output | 165 | Latched word, sliced to the units by slot position |

## Verification
Two events can meet in one cycle: a compare that writes a predicate, and a slot in the same word that is guarded by that predicate. The bench places both in one word and expects the guarded slot to use the old predicate value. It then expects the word that follows to use the new value. The second meeting is between a stall and a word that is ready to issue, including a compare. Busy is raised on the same cycle, and the bench requires that no strobe fires, that no predicate changes, and that the held word issues unchanged once busy drops.

// File: rtl/wide_issue_ctrl.sv
module wide_issue_ctrl #(
  parameter int NSLOT    = 5,
  parameter int PIDX_W   = 4,
  parameter int OPC_W    = 4,
  parameter int FLD_W    = 8,
  parameter logic [3:0] OP_CMPEQ = 4'h1,
  localparam int SLOT_W  = 1 + PIDX_W + OPC_W + 3*FLD_W,
  localparam int WORD_W  = NSLOT * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  input  logic [NSLOT-1:0]  unit_busy,
  input  logic              cmp_eq,
  output logic [NSLOT-1:0]  unit_go,
  output logic [WORD_W-1:0] unit_word
);
  localparam int NPRED   = 1 << PIDX_W;
  localparam int BR      = NSLOT - 1;
  localparam int V_BIT   = SLOT_W - 1;
  localparam int P_LO    = 3*FLD_W + OPC_W;
  localparam int OP_LO   = 3*FLD_W;
  localparam int RD_LO   = 2*FLD_W;

  logic              stall;
  logic              cur_valid;
  logic [WORD_W-1:0] cur_word;
  logic [NPRED-1:0]  pred;

  assign stall     = |unit_busy;
  assign in_ready  = ~stall;
  assign unit_word = cur_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid <= 1'b0;
      cur_word  <= '0;
    end else if (!stall) begin
      cur_valid <= in_valid;
      cur_word  <= in_word;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [SLOT_W-1:0] s;
    assign s = cur_word[i*SLOT_W +: SLOT_W];
    assign unit_go[i] = cur_valid & ~stall & s[V_BIT] & pred[s[P_LO +: PIDX_W]];
  end

  logic [SLOT_W-1:0] br_slot;
  logic              cmp_fire;
  logic [PIDX_W-1:0] cmp_pt, cmp_pf;

  assign br_slot  = cur_word[BR*SLOT_W +: SLOT_W];
  assign cmp_fire = unit_go[BR] & (br_slot[OP_LO +: OPC_W] == OP_CMPEQ);
  assign cmp_pt   = br_slot[RD_LO + PIDX_W +: PIDX_W];
  assign cmp_pf   = br_slot[RD_LO +: PIDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred <= NPRED'(1);
    end else if (cmp_fire) begin
      if (cmp_pt != '0) pred[cmp_pt] <= cmp_eq;
      if (cmp_pf != '0) pred[cmp_pf] <= ~cmp_eq;
    end
  end
endmodule

module wide_issue_ctrl_chk #(
  parameter int NSLOT  = 5,
  parameter int PIDX_W = 4,
  parameter int SLOT_W = 33
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cur_valid,
  input logic [NSLOT-1:0]        unit_busy,
  input logic [NSLOT-1:0]        unit_go,
  input logic [NSLOT*SLOT_W-1:0] unit_word
);
  assert_stall_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_busy) |-> (unit_go == '0));

  assert_hold_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_busy) |=> $stable(unit_word) && $stable(cur_valid));

  for (genvar i = 0; i < NSLOT; i++) begin : g_chk
    assert_nop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_word[i*SLOT_W + SLOT_W - 1] |-> !unit_go[i]);

    assert_p0_issues_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && !(|unit_busy) && unit_word[i*SLOT_W + SLOT_W - 1]
       && unit_word[i*SLOT_W + SLOT_W - 2 -: PIDX_W] == '0) |-> unit_go[i]);
  end
endmodule

bind wide_issue_ctrl wide_issue_ctrl_chk #(
  .NSLOT(NSLOT), .PIDX_W(PIDX_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid),
  .unit_busy(unit_busy), .unit_go(unit_go), .unit_word(unit_word)
);

// File: tb/wide_issue_ctrl_bench.sv
module wide_issue_ctrl_bench;
  localparam int SW = 33;
  localparam int NS = 5;
  localparam int WW = NS * SW;
  localparam logic [3:0] CMP = 4'h1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic          in_ready;
  logic [NS-1:0] unit_busy = '0;
  logic          cmp_eq = 1'b0;
  logic [NS-1:0] unit_go;
  logic [WW-1:0] unit_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [WW-1:0] m_word;
  logic          m_val;
  logic [15:0]   m_pred;

  always #5 clk = ~clk;

  wide_issue_ctrl u_wide_issue_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .unit_busy(unit_busy), .cmp_eq(cmp_eq),
    .unit_go(unit_go), .unit_word(unit_word)
  );

  function automatic logic [SW-1:0] mk(input logic v, input logic [3:0] p,
      input logic [3:0] op, input logic [7:0] rd, input logic [7:0] ra, input logic [7:0] rb);
    return {v, p, op, rd, ra, rb};
  endfunction

  function automatic logic [NS-1:0] exp_go(input logic [NS-1:0] b);
    logic [NS-1:0] g;
    for (int i = 0; i < NS; i++) begin
      logic [SW-1:0] s;
      s = m_word[i*SW +: SW];
      g[i] = m_val && (b == '0) && s[32] && m_pred[s[31:28]];
    end
    return g;
  endfunction

  task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic iv, input logic [WW-1:0] w,
                      input logic [NS-1:0] b, input logic ce);
    logic [NS-1:0] g;
    logic [SW-1:0] br;
    @(negedge clk);
    in_valid = iv; in_word = w; unit_busy = b; cmp_eq = ce;
    #1;
    g = exp_go(b);
    chk({tag, " go"}, WW'(unit_go), WW'(g));
    chk({tag, " R11 ready"}, WW'(in_ready), WW'(b == '0));
    chk({tag, " R2 word"}, unit_word, m_word);
    @(posedge clk);
    br = m_word[4*SW +: SW];
    if (g[4] && br[27:24] == CMP) begin
      if (br[23:20] != 0) m_pred[br[23:20]] = ce;
      if (br[19:16] != 0) m_pred[br[19:16]] = ~ce;
    end
    if (b == '0) begin m_word = w; m_val = iv; end
  endtask

  function automatic logic [SW-1:0] rnd_slot(input bit is_br);
    logic [3:0] op;
    op = ($urandom % 3 == 0 && is_br) ? CMP : 4'($urandom);
    return mk(($urandom % 4) != 0, 4'($urandom % 8), op,
              8'($urandom), 8'($urandom), 8'($urandom));
  endfunction

  function automatic logic [WW-1:0] all_p0(input logic [7:0] rd);
    logic [WW-1:0] w;
    for (int i = 0; i < NS; i++) w[i*SW +: SW] = mk(1, 0, 4'h2, rd, 8'h10, 8'h11);
    return w;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] w;
    void'($urandom(32'd7061));
    m_word = '0; m_val = 0; m_pred = 16'h0001;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset go", WW'(unit_go), '0);
    chk("R1 reset ready", WW'(in_ready), WW'(1));

    // R1: reset predicates false; R3 no-op slot
    w = '0;
    w[0*SW +: SW] = mk(1, 4'd5, 4'h2, 1, 2, 3);
    w[1*SW +: SW] = mk(0, 4'd0, 4'h2, 1, 2, 3);
    w[2*SW +: SW] = mk(1, 4'd0, 4'h3, 1, 2, 3);
    step("R1 R3 load", 1, w, 0, 0);
    step("R1 R3 R5 issue", 0, '0, 0, 0);

    // R12: all slots name same fields, all issue
    step("R12 load", 1, all_p0(8'h07), 0, 0);
    step("R12 issue", 0, '0, 0, 0);

    // R6/R7: compare p3 (true), p4 (false); slot0 in same word guarded by p3
    w = '0;
    w[0*SW +: SW] = mk(1, 4'd3, 4'h2, 1, 2, 3);
    w[4*SW +: SW] = mk(1, 4'd0, CMP, 8'h34, 2, 3);
    step("R7 load", 1, w, 0, 0);
    w = '0;
    w[0*SW +: SW] = mk(1, 4'd3, 4'h2, 1, 2, 3);
    w[1*SW +: SW] = mk(1, 4'd4, 4'h2, 1, 2, 3);
    step("R7 same-word squash", 1, w, 0, 1);
    step("R6 pair written", 0, '0, 0, 0);

    // R8: same index both destinations, eq=1 -> p6 false
    w = '0;
    w[4*SW +: SW] = mk(1, 4'd0, CMP, 8'h66, 2, 3);
    step("R8 load", 1, w, 0, 0);
    w = '0;
    w[2*SW +: SW] = mk(1, 4'd6, 4'h2, 1, 2, 3);
    step("R8 cmp", 1, w, 0, 1);
    step("R8 check", 0, '0, 0, 0);

    // R5: compare aimed at p0 with eq=0
    w = '0;
    w[4*SW +: SW] = mk(1, 4'd0, CMP, 8'h00, 2, 3);
    step("R5 load", 1, w, 0, 0);
    step("R5 cmp", 1, all_p0(8'h01), 0, 0);
    step("R5 check", 0, '0, 0, 0);

    // R4: squashed compare (guard p4 false) writes nothing
    w = '0;
    w[4*SW +: SW] = mk(1, 4'd4, CMP, 8'h9A, 2, 3);
    step("R4 load", 1, w, 0, 0);
    w = '0;
    w[0*SW +: SW] = mk(1, 4'd9, 4'h2, 1, 2, 3);
    w[1*SW +: SW] = mk(1, 4'd10, 4'h2, 1, 2, 3);
    step("R4 squash cmp", 1, w, 0, 1);
    step("R4 check", 0, '0, 0, 0);

    // R9/R10/R11: stall on a ready compare word, offered word ignored
    w = '0;
    w[4*SW +: SW] = mk(1, 4'd0, CMP, 8'hBC, 2, 3);
    w[0*SW +: SW] = mk(1, 4'd0, 4'h2, 1, 2, 3);
    step("R9 load", 1, w, 0, 0);
    step("R9 R10 stall", 1, all_p0(8'h55), 5'b00100, 1);
    step("R10 stall again", 1, all_p0(8'h66), 5'b10000, 0);
    w = '0;
    w[0*SW +: SW] = mk(1, 4'd11, 4'h2, 1, 2, 3);
    w[1*SW +: SW] = mk(1, 4'd12, 4'h2, 1, 2, 3);
    step("R10 release", 1, w, 0, 1);
    step("R6 after stall", 0, '0, 0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [WW-1:0] rw;
      for (int i = 0; i < NS; i++) rw[i*SW +: SW] = rnd_slot(i == 4);
      step("R2 R4 R6 R9 random", ($urandom % 8) != 0, rw,
           ($urandom % 5 == 0) ? NS'($urandom) : '0, 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule